// File: doc/BRIEF.md
# Channel Operating Mode Controller

This block is the digital sequencer that sets the operating mode of a disk read/write channel. A host writes a mode code through a strobe, and the controller holds that mode. It drives the power enables of the channel sections from the mode and from the read and write gates. It also drives the control that shorts the filter and gain-stage inputs, the gain-hold enable, a fast-acquisition pulse for the gain loop, and the output enables of the NRZ data and address-mark-detect pins. A further output sets the direction of the read-data pin.

There are six modes: full power-down, idle, read, write, servo 1 and servo 2. A move from power-down straight into write is refused. The controller stays in power-down and raises a sticky sequence-error flag. A code outside the six defined ones gets the same treatment. The flag clears on the next accepted mode write. The analog circuits, the serial port and the loop filters are not modelled here. The block produces only their enables and their sequencing.

Top module: `chan_mode_ctrl`

## Requirements
- R1: In power-down (mode code 0), every power enable, output enable, input short, gain hold, fast-acquisition pulse, forced-high and read-data-direction output is low.
- R2: A write of code 3 (write) while in power-down leaves the mode at power-down and sets `seq_err` at the next clock edge.
- R3: In write mode (code 3), `fe_pwr_en`, `pdet_pwr_en`, `agc_hold_en`, `nrz_out_oe`, `amd_out_oe` and `rdata_dir_out` are low, `synth_pwr_en` and `dsep_pwr_en` are high, and `in_short` follows `write_gate`.
- R4: In write mode, `agc_fast_acq` is high for the cycle in which `write_gate` is low after being high at the previous clock edge, and `in_short` is then low.
- R5: In idle (code 1), all four power enables, `agc_hold_en`, `amd_out_oe`, `amd_force_high` and `rdata_dir_out` are high, and `nrz_out_oe` and `in_short` are low.
- R6: In servo 1 (code 4), all four power enables and `rdata_dir_out` are high, and `agc_hold_en`, `in_short` and both output enables are low.
- R7: Servo 2 (code 5) equals servo 1 except that `synth_pwr_en`, `dsep_pwr_en` and `fe_pwr_en` are low. Only `pdet_pwr_en` stays on.
- R8: In read (code 2), all four power enables and `agc_hold_en` are high, `rdata_dir_out` and `in_short` are low, and `nrz_out_oe` and `amd_out_oe` both follow `read_gate`.
- R9: Any code above 5 is refused in every mode: the mode is unchanged and `seq_err` sets. `seq_err` stays set until an accepted mode write clears it.
- R10: While `rst_n` is low at a clock edge, the mode becomes power-down and `seq_err` clears. An accepted write sampled at an edge takes effect from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_wr | input | 1 | Mode write strobe |
| mode_code | input | MODE_W | Requested mode code |
| read_gate | input | 1 | Read gate |
| write_gate | input | 1 | Write gate |
| fe_pwr_en | output | 1 | Front-end gain stage power |
| synth_pwr_en | output | 1 | Frequency synthesizer power |
| dsep_pwr_en | output | 1 | Data separator power |
| pdet_pwr_en | output | 1 | Pulse detector and filter power |
| in_short | output | 1 | Short filter and gain-stage inputs |
| agc_hold_en | output | 1 | Gain hold input enabled |
| agc_fast_acq | output | 1 | Fast gain-acquisition pulse |
| nrz_out_oe | output | 1 | NRZ read output enable |
| amd_out_oe | output | 1 | Address-mark-detect output enable |
| amd_force_high | output | 1 | Address-mark-detect held high |
| rdata_dir_out | output | 1 | Read-data pin driven as output |
| seq_err | output | 1 | Sticky illegal-sequence flag |

## Verification
The bench attacks the power-down-to-write refusal. A design that lets this move through would enter write mode, raise the synthesizer enables and leave `seq_err` low. It also sends unknown codes from power-down and from read. Here a design that gets it wrong would change mode or lose the flag, and a flag that clears by itself shows up on an idle cycle. The falling write gate is checked on the cycle of the fall and again on the next cycle. A missing pulse, a pulse that lasts too long, or a short that persists would each show there. Reset is applied in the middle of servo operation to confirm the return to power-down.

// File: rtl/chan_mode_pkg.sv
package chan_mode_pkg;
   typedef enum logic [2:0] {
      CM_PDN    = 3'd0,
      CM_IDLE   = 3'd1,
      CM_READ   = 3'd2,
      CM_WRITE  = 3'd3,
      CM_SERVO1 = 3'd4,
      CM_SERVO2 = 3'd5
   } chan_mode_e;

   localparam int CM_LAST_CODE = 5;

   typedef struct packed {
      logic fe;
      logic synth;
      logic dsep;
      logic pdet;
      logic in_short;
      logic agc_hold;
      logic fast_acq;
      logic nrz_oe;
      logic amd_oe;
      logic amd_hi;
      logic rdata_out;
   } chan_ctl_t;
endpackage

// File: rtl/chan_mode_fsm.sv
module chan_mode_fsm
   import chan_mode_pkg::*;
#(
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_code,
   output chan_mode_e        mode_q,
   output logic              err_q
);
   localparam logic [MODE_W-1:0] WRITE_CODE = MODE_W'(CM_WRITE);
   localparam logic [MODE_W-1:0] LAST_CODE  = MODE_W'(CM_LAST_CODE);

   logic code_known;
   logic pdn_to_write;
   logic accept;
   logic reject;

   always_comb begin
      code_known   = (mode_code <= LAST_CODE);
      pdn_to_write = (mode_q == CM_PDN) && (mode_code == WRITE_CODE);
      accept       = mode_wr && code_known && !pdn_to_write;
      reject       = mode_wr && !accept;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= CM_PDN;
         err_q  <= 1'b0;
      end else if (accept) begin
         mode_q <= chan_mode_e'(mode_code[2:0]);
         err_q  <= 1'b0;
      end else if (reject) begin
         err_q  <= 1'b1;
      end
   end

   assert_pdn_blocks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CM_PDN && mode_wr && mode_code == WRITE_CODE) |=> (mode_q == CM_PDN && err_q));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !mode_wr) |=> err_q);

   assert_unknown_keeps_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_code > LAST_CODE) |=> ($stable(mode_q) && err_q));

   assert_reset_to_pdn_R10: assert property (@(posedge clk)
      !rst_n |=> (mode_q == CM_PDN && !err_q));
endmodule

// File: rtl/chan_mode_decode.sv
module chan_mode_decode
   import chan_mode_pkg::*;
(
   input  chan_mode_e mode,
   input  logic       read_gate,
   input  logic       write_gate,
   input  logic       write_gate_q,
   output chan_ctl_t  ctl
);
   always_comb begin
      ctl = '0;
      unique case (mode)
         CM_IDLE: begin
            ctl.fe        = 1'b1;
            ctl.synth     = 1'b1;
            ctl.dsep      = 1'b1;
            ctl.pdet      = 1'b1;
            ctl.agc_hold  = 1'b1;
            ctl.amd_oe    = 1'b1;
            ctl.amd_hi    = 1'b1;
            ctl.rdata_out = 1'b1;
         end
         CM_READ: begin
            ctl.fe        = 1'b1;
            ctl.synth     = 1'b1;
            ctl.dsep      = 1'b1;
            ctl.pdet      = 1'b1;
            ctl.agc_hold  = 1'b1;
            ctl.nrz_oe    = read_gate;
            ctl.amd_oe    = read_gate;
         end
         CM_WRITE: begin
            ctl.synth     = 1'b1;
            ctl.dsep      = 1'b1;
            ctl.in_short  = write_gate;
            ctl.fast_acq  = write_gate_q && !write_gate;
         end
         CM_SERVO1: begin
            ctl.fe        = 1'b1;
            ctl.synth     = 1'b1;
            ctl.dsep      = 1'b1;
            ctl.pdet      = 1'b1;
            ctl.rdata_out = 1'b1;
         end
         CM_SERVO2: begin
            ctl.pdet      = 1'b1;
            ctl.rdata_out = 1'b1;
         end
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/chan_mode_outstage.sv
module chan_mode_outstage
   import chan_mode_pkg::*;
#(
   parameter bit REG_OUTPUTS = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  chan_ctl_t ctl_d,
   output chan_ctl_t ctl_q
);
   if (REG_OUTPUTS) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) ctl_q <= '0;
         else        ctl_q <= ctl_d;
      end
   end else begin : g_comb
      assign ctl_q = ctl_d;
   end
endmodule

// File: rtl/chan_mode_ctrl.sv
module chan_mode_ctrl
   import chan_mode_pkg::*;
#(
   parameter int MODE_W      = 3,
   parameter bit REG_OUTPUTS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_code,
   input  logic              read_gate,
   input  logic              write_gate,
   output logic              fe_pwr_en,
   output logic              synth_pwr_en,
   output logic              dsep_pwr_en,
   output logic              pdet_pwr_en,
   output logic              in_short,
   output logic              agc_hold_en,
   output logic              agc_fast_acq,
   output logic              nrz_out_oe,
   output logic              amd_out_oe,
   output logic              amd_force_high,
   output logic              rdata_dir_out,
   output logic              seq_err
);
   if (MODE_W < 3 || MODE_W > 16) begin : g_bad_width
      $error("chan_mode_ctrl: MODE_W must lie in 3..16");
   end

   chan_mode_e mode_q;
   logic       err_q;
   logic       wg_q;
   chan_ctl_t  ctl_d;
   chan_ctl_t  ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) wg_q <= 1'b0;
      else        wg_q <= write_gate;
   end

   chan_mode_fsm #(.MODE_W(MODE_W)) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_code (mode_code),
      .mode_q    (mode_q),
      .err_q     (err_q)
   );

   chan_mode_decode dec_i (
      .mode         (mode_q),
      .read_gate    (read_gate),
      .write_gate   (write_gate),
      .write_gate_q (wg_q),
      .ctl          (ctl_d)
   );

   chan_mode_outstage #(.REG_OUTPUTS(REG_OUTPUTS)) out_i (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl_d (ctl_d),
      .ctl_q (ctl_q)
   );

   assign fe_pwr_en      = ctl_q.fe;
   assign synth_pwr_en   = ctl_q.synth;
   assign dsep_pwr_en    = ctl_q.dsep;
   assign pdet_pwr_en    = ctl_q.pdet;
   assign in_short       = ctl_q.in_short;
   assign agc_hold_en    = ctl_q.agc_hold;
   assign agc_fast_acq   = ctl_q.fast_acq;
   assign nrz_out_oe     = ctl_q.nrz_oe;
   assign amd_out_oe     = ctl_q.amd_oe;
   assign amd_force_high = ctl_q.amd_hi;
   assign rdata_dir_out  = ctl_q.rdata_out;
   assign seq_err        = err_q;

   if (!REG_OUTPUTS) begin : g_port_checks
      assert_pdn_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q == CM_PDN) |-> !(fe_pwr_en || synth_pwr_en || dsep_pwr_en || pdet_pwr_en
                                  || nrz_out_oe || amd_out_oe || in_short || agc_hold_en));

      assert_write_floats_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q == CM_WRITE) |-> (!nrz_out_oe && !amd_out_oe && !fe_pwr_en && !agc_hold_en));

      assert_fast_acq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
         agc_fast_acq |=> !agc_fast_acq);

      assert_fast_acq_unshort_R4: assert property (@(posedge clk) disable iff (!rst_n)
         agc_fast_acq |-> (!in_short && mode_q == CM_WRITE));

      assert_servo2_low_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q == CM_SERVO2) |-> (!synth_pwr_en && !dsep_pwr_en && pdet_pwr_en));

      assert_read_pin_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q == CM_READ) |-> (!rdata_dir_out && agc_hold_en && nrz_out_oe == read_gate));
   end
endmodule

// File: tb/chan_mode_ctrl_tb_top.sv
module chan_mode_ctrl_tb_top;
   localparam int MODE_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_wr = 1'b0;
   logic [MODE_W-1:0] mode_code = '0;
   logic read_gate = 1'b0;
   logic write_gate = 1'b0;

   logic fe_pwr_en, synth_pwr_en, dsep_pwr_en, pdet_pwr_en, in_short, agc_hold_en;
   logic agc_fast_acq, nrz_out_oe, amd_out_oe, amd_force_high, rdata_dir_out, seq_err;

   always #2.5 clk = ~clk;

   chan_mode_ctrl #(.MODE_W(MODE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
      .read_gate(read_gate), .write_gate(write_gate),
      .fe_pwr_en(fe_pwr_en), .synth_pwr_en(synth_pwr_en), .dsep_pwr_en(dsep_pwr_en),
      .pdet_pwr_en(pdet_pwr_en), .in_short(in_short), .agc_hold_en(agc_hold_en),
      .agc_fast_acq(agc_fast_acq), .nrz_out_oe(nrz_out_oe), .amd_out_oe(amd_out_oe),
      .amd_force_high(amd_force_high), .rdata_dir_out(rdata_dir_out), .seq_err(seq_err)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [11:0] exp_q[$];
   string       tag_q[$];

   // bench model of the mode state
   int   m_mode = 0;
   logic m_err  = 1'b0;
   logic m_wgq  = 1'b0;

   // bits: fe synth dsep pdet short hold acq nrz amd_oe amd_hi rdir err
   function automatic logic [11:0] expect_vec(int md, logic rg, logic wg, logic wgq, logic er);
      logic [11:0] v;
      v = '0;
      case (md)
         1: v = 12'b1111_0100_1110;
         2: v = {4'b1111, 1'b0, 1'b1, 1'b0, rg, rg, 1'b0, 1'b0, 1'b0};
         3: v = {4'b0110, wg, 1'b0, (wgq && !wg), 5'b00000};
         4: v = 12'b1111_0000_0010;
         5: v = 12'b0001_0000_0010;
         default: v = '0;
      endcase
      v[0] = er;
      return v;
   endfunction

   task automatic drive(input logic rst, input logic wr, input int code,
                        input logic rg, input logic wg, input string tag);
      @(negedge clk);
      rst_n      = rst;
      mode_wr    = wr;
      mode_code  = MODE_W'(code);
      read_gate  = rg;
      write_gate = wg;
      #1;
      exp_q.push_back(expect_vec(m_mode, rg, wg, m_wgq, m_err));
      tag_q.push_back(tag);
      if (!rst) begin
         m_mode = 0; m_err = 1'b0; m_wgq = 1'b0;
      end else begin
         if (wr) begin
            if (code > 5 || (m_mode == 0 && code == 3)) m_err = 1'b1;
            else begin m_mode = code; m_err = 1'b0; end
         end
         m_wgq = wg;
      end
   endtask

   initial begin : monitor
      logic [11:0] got;
      logic [11:0] want;
      string t;
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            want = exp_q.pop_front();
            t    = tag_q.pop_front();
            got  = {fe_pwr_en, synth_pwr_en, dsep_pwr_en, pdet_pwr_en, in_short, agc_hold_en,
                    agc_fast_acq, nrz_out_oe, amd_out_oe, amd_force_high, rdata_dir_out, seq_err};
            checks++;
            if (got !== want) begin
               failures++;
               $display("FAIL %s: outputs=%b expected=%b", t, got, want);
            end
         end
      end
   end

   initial begin : watchdog
      #100000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stimulus
      drive(0, 0, 0, 0, 0, "R10 reset");
      drive(0, 1, 1, 1, 1, "R10 reset ignores write");
      drive(1, 0, 0, 1, 1, "R1 power-down with gates high");
      drive(1, 1, 3, 0, 0, "R2 write request from power-down");
      drive(1, 0, 0, 0, 1, "R2 stays power-down, flag set");
      drive(1, 0, 0, 0, 0, "R9 flag sticky");
      drive(1, 1, 7, 0, 0, "R9 unknown code from power-down");
      drive(1, 1, 1, 0, 0, "R9 legal write issued");
      drive(1, 0, 0, 0, 0, "R5 idle, flag cleared");
      drive(1, 1, 2, 1, 0, "R5 idle ignores read gate");
      drive(1, 0, 0, 0, 0, "R8 read gate low");
      drive(1, 0, 0, 1, 0, "R8 read gate high");
      drive(1, 1, 6, 1, 0, "R8 read with unknown request");
      drive(1, 0, 0, 1, 0, "R9 unknown code keeps read");
      drive(1, 1, 3, 0, 0, "R9 write code from read accepted");
      drive(1, 0, 0, 0, 1, "R3 write gate high shorts inputs");
      drive(1, 0, 0, 0, 1, "R3 write gate held");
      drive(1, 0, 0, 0, 0, "R4 write gate falls");
      drive(1, 0, 0, 0, 0, "R4 pulse ends");
      drive(1, 1, 4, 0, 0, "R4 leave write");
      drive(1, 0, 0, 1, 1, "R6 servo 1");
      drive(1, 1, 5, 0, 0, "R6 servo 1 before switch");
      drive(1, 0, 0, 1, 0, "R7 servo 2");
      drive(1, 1, 4, 0, 0, "R7 servo 2 before switch");
      drive(1, 0, 0, 0, 0, "R6 servo 1 again");
      drive(0, 0, 0, 0, 0, "R10 reset mid-servo");
      drive(1, 0, 0, 0, 0, "R10 back in power-down");
      drive(1, 1, 0, 0, 0, "R1 explicit power-down write");
      drive(1, 1, 3, 0, 1, "R2 second blocked write");
      drive(1, 0, 0, 0, 1, "R2 no short after refused write");
      drive(1, 0, 0, 0, 0, "R9 idle cycle");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule